// File: doc/BRIEF.md
# PHY Management Frame Register

This block gives a host a single 32-bit management word through which it reads and writes a small PHY register file held inside the block. The host writes one frame word. The block splits it into a start code, an opcode, a PHY address, a register address and a 16-bit data field, and carries out the access in the same clock edge. It then stores the word back with a completion flag set, so software can poll for completion. A read access also puts the addressed register value into the data field of the stored word.

The register file holds 32 entries of 16 bits. The control entry has self-clearing reset and negotiation-restart bits. The status and link-partner entries follow a `link_up` input. Any change of `link_up` sets a 16-bit management interrupt status. That status clears when the host reads it. An interrupt output is raised when a status bit is set and its bit in a host-writable mask is clear.

Host accesses use a plain valid/write/address/data bus. Read data appears one cycle after the request.

Top module: `mgmt_frame_port`

## Requirements
- R1: Reset sets the following state. The frame word reads 0x00000000, the mask reads 0x0000FFFF, the interrupt status reads 0 and `irq` is low. PHY entry 1 (status) holds 0x4028, with bit 2 also set when `link_up` is high during reset. Entry 4 (advertisement) holds 0x0100. Entry 5 (partner ability) holds 0x0100 when `link_up` is high and 0 otherwise. Every other entry holds 0.
- R2: An access is carried out only when the frame start code (bits 31:30) is 01 and the PHY address (bits 27:23) equals `PHY_ADDR`, which defaults to 1. Any other frame leaves every PHY entry unchanged.
- R3: Every frame write stores the written word with bit 16 forced to 1. All other bits are stored as written, except for the data field of a valid read.
- R4: Opcode (bits 29:28) 01 writes data bits 15:0 to the entry selected by bits 22:18. Opcodes 00 and 11 access no entry and leave bits 15:0 as written.
- R5: Opcode 10 replaces bits 15:0 of the stored frame word with the current value of the selected entry.
- R6: A write to entry 0 with bit 15 set stores the value with bit 15 cleared and bit 12 set.
- R7: A write to entry 0 with bit 9 set stores bit 9 cleared and sets bit 5 of entry 1. If `link_up` is high, it also sets bit 2 of entry 1 and bit 8 of entry 5.
- R8: A change of `link_up` copies the new level into entry 1 bit 2 and entry 5 bit 8 and sets the interrupt status to 0xFFFF. It takes effect one edge after the change, and it takes priority over a status read-clear in the same cycle.
- R9: A host read of address 2 returns the interrupt status and then clears it.
- R10: `irq` is high exactly when some status bit is 1 while the same mask bit is 0.
- R11: Host map: address 0 is the frame word, address 1 is the mask (bits 15:0, writable), address 2 is the status (writes ignored) and address 3 reads 0. `host_rdata` is valid on the cycle after the request and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Host access request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | HOST_AW | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, one cycle after request |
| link_up | input | 1 | Link level from the line side |
| irq | output | 1 | Management interrupt |

## Verification
Frames are driven with a correct header and then with each header field wrong in turn: start codes 00 and 11, PHY addresses 0 and 2, and opcodes 00 and 11. The bench then reads back a written entry, which shows whether the access was gated on the start code, on the PHY address or on the opcode. Control writes are made with the reset bit alone, with the reset bit plus other bits, and with the restart bit under link up and under link down. These separate the self-clearing rules from the link-dependent side effects. Link changes are made while the interrupt is masked, while it is unmasked, and in the same cycle as a status read, which checks both the masking and the set-over-clear priority.

// File: rtl/mgmt_frame_pkg.sv
package mgmt_frame_pkg;

   // frame word field positions (the PHY decodes these)
   localparam int ST_HI   = 31;
   localparam int ST_LO   = 30;
   localparam int OP_HI   = 29;
   localparam int OP_LO   = 28;
   localparam int PHY_HI  = 27;
   localparam int PHY_LO  = 23;
   localparam int REG_HI  = 22;
   localparam int REG_LO  = 18;
   localparam int DONE_B  = 16;
   localparam int DATA_HI = 15;

   localparam logic [1:0] START_CODE = 2'b01;

   typedef enum logic [1:0] {
      OP_IDLE0 = 2'b00,
      OP_WR    = 2'b01,
      OP_RD    = 2'b10,
      OP_IDLE3 = 2'b11
   } mgmt_op_e;

   // PHY register file entries
   localparam int E_CTRL    = 0;
   localparam int E_STAT    = 1;
   localparam int E_ADV     = 4;
   localparam int E_PARTNER = 5;

   // bit positions inside entries
   localparam int CTRL_RST     = 15;
   localparam int CTRL_ANEN    = 12;
   localparam int CTRL_RESTART = 9;
   localparam int STAT_ANDONE  = 5;
   localparam int STAT_LINK    = 2;
   localparam int ABIL_100FD   = 8;

   localparam logic [15:0] STAT_INIT = 16'h4028;
   localparam logic [15:0] ADV_INIT  = 16'h0100;

   // host word addresses
   localparam int HA_FRAME  = 0;
   localparam int HA_MASK   = 1;
   localparam int HA_STATUS = 2;

   function automatic logic [15:0] entry_init(input int idx, input logic link);
      logic [15:0] v;
      v = '0;
      if (idx == E_STAT) begin
         v = STAT_INIT;
         v[STAT_LINK] = link;
      end else if (idx == E_ADV) begin
         v = ADV_INIT;
      end else if (idx == E_PARTNER) begin
         v[ABIL_100FD] = link;
      end
      return v;
   endfunction

endpackage

// File: rtl/mgmt_frame_decode.sv
module mgmt_frame_decode
   import mgmt_frame_pkg::*;
#(
   parameter int PHY_ADDR = 1
) (
   input  logic [31:0] word,
   output logic        acc_ok,
   output logic        do_wr,
   output logic        do_rd,
   output logic [4:0]  reg_idx
);
   mgmt_op_e op;

   always_comb begin
      op      = mgmt_op_e'(word[OP_HI:OP_LO]);
      reg_idx = word[REG_HI:REG_LO];
      acc_ok  = (word[ST_HI:ST_LO] == START_CODE) &&
                (word[PHY_HI:PHY_LO] == 5'(PHY_ADDR));
      do_wr   = acc_ok && (op == OP_WR);
      do_rd   = acc_ok && (op == OP_RD);
   end
endmodule

// File: rtl/mgmt_phy_regs.sv
module mgmt_phy_regs
   import mgmt_frame_pkg::*;
#(
   parameter int REG_COUNT = 32,
   parameter int DATA_W    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              link_up,
   input  logic              link_evt,
   input  logic              wr_en,
   input  logic [4:0]        idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rd_data
);
   logic [REG_COUNT-1:0][DATA_W-1:0] regs_q, regs_nxt;
   logic [DATA_W-1:0] wval;

   always_comb begin
      regs_nxt = regs_q;
      wval     = wdata;
      if (wr_en && idx == 5'(E_CTRL)) begin
         if (wval[CTRL_RST]) begin
            wval[CTRL_RST]  = 1'b0;
            wval[CTRL_ANEN] = 1'b1;
         end
         if (wval[CTRL_RESTART]) begin
            wval[CTRL_RESTART] = 1'b0;
            regs_nxt[E_STAT][STAT_ANDONE] = 1'b1;
            if (link_up) begin
               regs_nxt[E_STAT][STAT_LINK]     = 1'b1;
               regs_nxt[E_PARTNER][ABIL_100FD] = 1'b1;
            end
         end
      end
      for (int i = 0; i < REG_COUNT; i++)
         if (wr_en && idx == 5'(i)) regs_nxt[i] = wval;
      if (link_evt) begin
         regs_nxt[E_STAT][STAT_LINK]     = link_up;
         regs_nxt[E_PARTNER][ABIL_100FD] = link_up;
      end
   end

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < REG_COUNT; i++)
         if (idx == 5'(i)) rd_data = regs_q[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= entry_init(i, link_up);
      end else begin
         regs_q <= regs_nxt;
      end
   end

   // R6: reset bit self-clears and enables negotiation
   p_ctrl_rst_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == 5'(E_CTRL) && wdata[CTRL_RST]) |=>
      (!regs_q[E_CTRL][CTRL_RST] && regs_q[E_CTRL][CTRL_ANEN]));

   // R7: restart marks negotiation complete
   p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && idx == 5'(E_CTRL) && wdata[CTRL_RESTART]) |=>
      (regs_q[E_STAT][STAT_ANDONE] && !regs_q[E_CTRL][CTRL_RESTART]));

   // R2: no access and no link event leaves the file untouched
   p_idle_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !link_evt) |=> $stable(regs_q));
endmodule

// File: rtl/mgmt_irq_unit.sv
module mgmt_irq_unit #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         link_evt,
   input  logic         rd_clear,
   input  logic         mask_we,
   input  logic [W-1:0] mask_wdata,
   output logic [W-1:0] status,
   output logic [W-1:0] mask,
   output logic         irq
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status <= '0;
         mask   <= '1;
      end else begin
         if (link_evt)      status <= '1;
         else if (rd_clear) status <= '0;
         if (mask_we)       mask   <= mask_wdata;
      end
   end

   assign irq = |(status & ~mask);

   // R8: link change sets every status bit
   p_evt_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
      link_evt |=> (status == '1));

   // R9: a read without a coincident event clears status
   p_rd_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_clear && !link_evt) |=> (status == '0));
endmodule

// File: rtl/mgmt_frame_port.sv
module mgmt_frame_port
   import mgmt_frame_pkg::*;
#(
   parameter int PHY_ADDR  = 1,
   parameter int REG_COUNT = 32,
   parameter int DATA_W    = 16,
   parameter int HOST_AW   = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_valid,
   input  logic               host_write,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [31:0]        host_wdata,
   output logic [31:0]        host_rdata,
   input  logic               link_up,
   output logic               irq
);
   localparam int PAD_W = 32 - DATA_W;

   generate
      if (DATA_W != 16) begin : g_bad_w
         $error("DATA_W must be 16 to fit the frame data field");
      end
      if (REG_COUNT < 6 || REG_COUNT > 32) begin : g_bad_cnt
         $error("REG_COUNT must lie in 6..32");
      end
      if (PHY_ADDR < 0 || PHY_ADDR > 31) begin : g_bad_phy
         $error("PHY_ADDR must fit in five bits");
      end
      if (HOST_AW < 2) begin : g_bad_aw
         $error("HOST_AW must be at least 2");
      end
   endgenerate

   logic        link_prev_q, link_evt;
   logic [31:0] frame_q, frame_nxt;
   logic        acc_ok, do_wr, do_rd;
   logic [4:0]  reg_idx;
   logic [DATA_W-1:0] phy_rd, status, mask;
   logic        frame_we, rd_req, rd_clear, mask_we;

   assign frame_we = host_valid && host_write && host_addr == HOST_AW'(HA_FRAME);
   assign mask_we  = host_valid && host_write && host_addr == HOST_AW'(HA_MASK);
   assign rd_req   = host_valid && !host_write;
   assign rd_clear = rd_req && host_addr == HOST_AW'(HA_STATUS);
   assign link_evt = link_up != link_prev_q;

   mgmt_frame_decode #(.PHY_ADDR(PHY_ADDR)) u_dec (
      .word   (host_wdata),
      .acc_ok (acc_ok),
      .do_wr  (do_wr),
      .do_rd  (do_rd),
      .reg_idx(reg_idx)
   );

   mgmt_phy_regs #(.REG_COUNT(REG_COUNT), .DATA_W(DATA_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .link_up (link_up),
      .link_evt(link_evt),
      .wr_en   (frame_we && do_wr),
      .idx     (reg_idx),
      .wdata   (host_wdata[DATA_HI:0]),
      .rd_data (phy_rd)
   );

   mgmt_irq_unit #(.W(DATA_W)) u_irq (
      .clk       (clk),
      .rst_n     (rst_n),
      .link_evt  (link_evt),
      .rd_clear  (rd_clear),
      .mask_we   (mask_we),
      .mask_wdata(host_wdata[DATA_W-1:0]),
      .status    (status),
      .mask      (mask),
      .irq       (irq)
   );

   always_comb begin
      frame_nxt         = host_wdata;
      frame_nxt[DONE_B] = 1'b1;
      if (do_rd) frame_nxt[DATA_HI:0] = phy_rd;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         link_prev_q <= link_up;
         frame_q     <= '0;
         host_rdata  <= '0;
      end else begin
         link_prev_q <= link_up;
         if (frame_we) frame_q <= frame_nxt;
         if (rd_req) begin
            if (host_addr == HOST_AW'(HA_FRAME))       host_rdata <= frame_q;
            else if (host_addr == HOST_AW'(HA_MASK))   host_rdata <= {{PAD_W{1'b0}}, mask};
            else if (host_addr == HOST_AW'(HA_STATUS)) host_rdata <= {{PAD_W{1'b0}}, status};
            else                                       host_rdata <= '0;
         end
      end
   end

   // R3: completion flag present after every frame write
   p_done_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      frame_we |=> frame_q[DONE_B]);

   // R3: the frame word moves only on a frame write
   p_frame_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_we |=> $stable(frame_q));

   // R11: read data holds between reads
   p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> $stable(host_rdata));
endmodule

// File: tb/mgmt_frame_port_test.sv
`timescale 1ns/1ps
module mgmt_frame_port_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_valid = 1'b0;
   logic        host_write = 1'b0;
   logic [1:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        link_up = 1'b1;
   logic        irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   // behavioural reference state
   int unsigned phy_m [32];
   int unsigned frame_m, mask_m, status_m;
   bit link_m;

   always #5 clk = ~clk;

   mgmt_frame_port uut (
      .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_write(host_write),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .link_up(link_up), .irq(irq)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input int st, input int op, input int phy,
                                      input int rg, input int dat);
      logic [31:0] w;
      w = {st[1:0], op[1:0], phy[4:0], rg[4:0], 2'b00, dat[15:0]};
      return w;
   endfunction

   function automatic bit irq_exp();
      return ((status_m & ~mask_m & 32'hFFFF) != 0);
   endfunction

   // wait one clock, compare the interrupt every clock (R10)
   task automatic step();
      @(negedge clk);
      chk("R10 irq", {31'd0, irq}, {31'd0, irq_exp()});
   endtask

   task automatic model_link(input bit v);
      if (v != link_m) begin
         link_m = v;
         if (v) begin phy_m[1] |= 32'h4;   phy_m[5] |= 32'h100; end
         else   begin phy_m[1] &= ~32'h4;  phy_m[5] &= ~32'h100; end
         status_m = 32'hFFFF;
      end
   endtask

   task automatic model_phy_wr(input int rg, input int unsigned d);
      int unsigned v;
      v = d & 32'hFFFF;
      if (rg == 0) begin
         if (v & 32'h8000) v = (v & ~32'h8000) | 32'h1000;
         if (v & 32'h0200) begin
            v &= ~32'h0200;
            phy_m[1] |= 32'h20;
            if (link_m) begin phy_m[1] |= 32'h4; phy_m[5] |= 32'h100; end
         end
      end
      phy_m[rg] = v;
   endtask

   task automatic host_wr(input int a, input logic [31:0] d);
      int unsigned st, op, ph, rg;
      host_valid = 1; host_write = 1; host_addr = a[1:0]; host_wdata = d;
      if (a == 0) begin
         st = d[31:30]; op = d[29:28]; ph = d[27:23]; rg = d[22:18];
         frame_m = d | 32'h10000;
         if (st == 1 && ph == 1) begin
            if (op == 1) model_phy_wr(rg, d[15:0]);
            else if (op == 2) frame_m = (frame_m & 32'hFFFF0000) | phy_m[rg];
         end
      end else if (a == 1) begin
         mask_m = d & 32'hFFFF;
      end
      step();
      host_valid = 0; host_write = 0;
   endtask

   task automatic host_rd(input int a, input string tag, output logic [31:0] v);
      int unsigned e;
      host_valid = 1; host_write = 0; host_addr = a[1:0];
      case (a)
         0: e = frame_m;
         1: e = mask_m;
         2: begin e = status_m; status_m = 0; end
         default: e = 0;
      endcase
      step();
      host_valid = 0;
      v = host_rdata;
      chk(tag, v, e);
   endtask

   task automatic phy_check(input int rg, input logic [15:0] lit, input string tag);
      logic [31:0] v;
      host_wr(0, mk(1, 2, 1, rg, 16'hDEAD));
      host_rd(0, tag, v);
      chk(tag, {16'd0, v[15:0]}, {16'd0, lit});
   endtask

   task automatic set_link(input bit v);
      link_up = v;
      model_link(v);
      step();
   endtask

   initial begin
      logic [31:0] v;
      for (int i = 0; i < 32; i++) phy_m[i] = 0;
      phy_m[1] = 32'h402C; phy_m[4] = 32'h0100; phy_m[5] = 32'h0100;
      link_m = 1; frame_m = 0; mask_m = 32'hFFFF; status_m = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      step();

      // R1 reset state, R11 map
      host_rd(0, "R1 frame after reset", v);
      host_rd(1, "R1 R11 mask after reset", v);
      host_rd(2, "R1 status after reset", v);
      phy_check(1, 16'h402C, "R1 R5 status entry");
      phy_check(4, 16'h0100, "R1 advert entry");
      phy_check(5, 16'h0100, "R1 partner entry");
      phy_check(7, 16'h0000, "R1 other entry");

      // R4 write, R5 read, R3 flag
      host_wr(0, mk(1, 1, 1, 20, 16'hA5C3));
      host_rd(0, "R3 frame after write", v);
      phy_check(20, 16'hA5C3, "R4 entry 20");
      host_wr(0, mk(1, 1, 1, 31, 16'h1234));
      phy_check(31, 16'h1234, "R4 last entry");

      // R2 bad start or PHY address
      host_wr(0, mk(0, 1, 1, 20, 16'h0F0F));
      host_rd(0, "R3 frame bad start", v);
      host_wr(0, mk(3, 1, 1, 20, 16'h0F0F));
      host_wr(0, mk(1, 1, 0, 20, 16'h0F0F));
      host_wr(0, mk(1, 1, 2, 20, 16'h0F0F));
      host_wr(0, mk(1, 2, 2, 20, 16'h7777));
      host_rd(0, "R2 read to other PHY keeps data", v);
      phy_check(20, 16'hA5C3, "R2 entry 20 untouched");

      // R4 idle opcodes
      host_wr(0, mk(1, 0, 1, 20, 16'h1111));
      host_rd(0, "R4 opcode 00 frame", v);
      host_wr(0, mk(1, 3, 1, 20, 16'h2222));
      host_rd(0, "R4 opcode 11 frame", v);
      phy_check(20, 16'hA5C3, "R4 entry 20 after idle opcodes");

      // R6 self-clearing reset bit
      host_wr(0, mk(1, 1, 1, 0, 16'h8000));
      phy_check(0, 16'h1000, "R6 reset bit");
      host_wr(0, mk(1, 1, 1, 0, 16'h8040));
      phy_check(0, 16'h1040, "R6 reset bit with others");

      // R7 restart with link up
      host_wr(0, mk(1, 1, 1, 1, 16'h0000));
      host_wr(0, mk(1, 1, 1, 5, 16'h0000));
      host_wr(0, mk(1, 1, 1, 0, 16'h0200));
      phy_check(0, 16'h0000, "R7 restart cleared");
      phy_check(1, 16'h0024, "R7 status link up");
      phy_check(5, 16'h0100, "R7 partner link up");

      // R8 link down
      set_link(0);
      phy_check(1, 16'h0020, "R8 status link down");
      phy_check(5, 16'h0000, "R8 partner link down");

      // R7 restart with link down
      host_wr(0, mk(1, 1, 1, 1, 16'h0000));
      host_wr(0, mk(1, 1, 1, 0, 16'h0200));
      phy_check(1, 16'h0020, "R7 status link down");
      phy_check(5, 16'h0000, "R7 partner link down");

      // R10 masking, R11 status write ignored, R9 read clear
      host_wr(1, 32'h0000FFFE);
      chk("R10 irq unmasked", {31'd0, irq}, 32'd1);
      host_rd(1, "R11 mask readback", v);
      host_wr(2, 32'h00000000);
      host_rd(2, "R9 R11 status survives write", v);
      host_rd(2, "R9 status cleared", v);
      chk("R10 irq after clear", {31'd0, irq}, 32'd0);

      // R8 link up event
      set_link(1);
      chk("R8 R10 irq after link up", {31'd0, irq}, 32'd1);
      phy_check(1, 16'h0024, "R8 status link up");
      host_wr(1, 32'h0000FFFF);
      chk("R10 irq masked", {31'd0, irq}, 32'd0);
      host_rd(3, "R11 unmapped reads zero", v);

      // R8 R9 event in same cycle as read-clear
      host_rd(2, "R9 clear before race", v);
      host_valid = 1; host_write = 0; host_addr = 2'd2; link_up = 0;
      begin
         int unsigned e;
         e = status_m;
         model_link(0);
         step();
         host_valid = 0;
         chk("R9 race read value", host_rdata, e);
      end
      host_rd(2, "R8 event wins over clear", v);
      chk("R8 status set after race", v, 32'h0000FFFF);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule